// File: doc/BRIEF.md
# Programmable Priority Chip-Select Decoder

This block turns a 24-bit memory address into four active-low chip-select strobes for external memory devices. Each strobe owns an address window set at run time by two 8-bit page bounds. The bounds are compared against the top eight address bits, so a window is always a whole number of 64 KB pages. When windows overlap, the lowest-numbered strobe wins. An address that lands in on-chip memory drives no strobe at all, even when a window covers it.

A strobe is driven only during a real memory cycle: the request strobe is low and either the read or the write strobe is low. Software programs the windows through a small write port made of a 4-bit register index and an 8-bit data word. After reset, strobe 0 covers the whole address space, so boot code can be fetched before anything is programmed.

Top module: `cs_window_decoder`

## Requirements
- R1: Output `cs_n[n]` is low when all of these hold: strobe n is enabled, its lower bound <= addr[23:16] <= its upper bound (unsigned), the access is qualified, internal memory is not hit, and no lower-numbered strobe matches.
- R2: When a strobe's lower and upper bounds are equal, it matches exactly one 64 KB page and no neighbouring page.
- R3: When a strobe's lower bound is greater than its upper bound, its window is empty and that strobe is never asserted.
- R4: When several enabled windows contain the address, only the lowest-numbered one is asserted. At most one output is low at any time.
- R5: While `int_hit` is high, all four outputs are high.
- R6: An access is qualified only when `mreq_n` is low and at least one of `rd_n` or `wr_n` is low. Otherwise all outputs are high.
- R7: Reset gives the following state. Strobe 0 has lower bound 00h, upper bound FFh and is enabled. Strobes 1 to 3 have both bounds at 00h and are disabled. The same state holds while reset is asserted.
- R8: Write-port field positions are as follows. `reg_idx[1:0]` selects the strobe. `reg_idx[3:2]` selects the field: 0 is the lower bound, 1 is the upper bound, 2 is control, where data bit 0 is the enable and the other data bits are ignored. Writes to field 3 are ignored. A write with `reg_we` high takes effect at the next rising clock edge.
- R9: A disabled strobe is never asserted, whatever its bounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously and is released synchronously |
| addr | input | 24 | Memory address |
| mreq_n | input | 1 | Active-low memory request |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| int_hit | input | 1 | High when the address targets internal memory |
| reg_we | input | 1 | Register write enable |
| reg_idx | input | 4 | Register index: strobe number in [1:0], field in [3:2] |
| reg_wdata | input | 8 | Register write data |
| cs_n | output | 4 | Active-low chip-select outputs |

## Verification
The assertions assume that `int_hit`, the strobes and the address are settled at each rising clock edge. They also assume that the write-port inputs are stable around that edge, because a bound loaded on one edge is checked on the next. The bench drives every input on the falling edge and reads the combinational outputs shortly after, so no input changes near the sampling edge. The random writes draw bounds from a few clustered values and the random addresses from pages near those bounds. This gives frequent overlaps, equal bounds and inverted bounds without breaking those assumptions.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;
  localparam int unsigned CS_NUM = 4;
  localparam int unsigned PAGE_W = 8;

  typedef enum logic [1:0] {
    FLD_LOWER = 2'd0,
    FLD_UPPER = 2'd1,
    FLD_CTRL  = 2'd2,
    FLD_RSVD  = 2'd3
  } reg_field_e;

  typedef struct packed {
    logic [PAGE_W-1:0] lower;
    logic [PAGE_W-1:0] upper;
    logic              enable;
  } cs_window_t;
endpackage

// File: rtl/cs_bound_regs.sv
module cs_bound_regs
  import cs_dec_pkg::*;
#(
  parameter int unsigned NUM_CS = CS_NUM,
  localparam int unsigned SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [SEL_W-1:0]         sel,
  input  reg_field_e               field,
  input  logic [PAGE_W-1:0]        wdata,
  output cs_window_t [NUM_CS-1:0]  win
);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    cs_window_t cur_q;
    cs_window_t nxt;
    logic       load;
    cs_window_t rst_val;

    assign rst_val.lower  = '0;
    assign rst_val.upper  = (g == 0) ? {PAGE_W{1'b1}} : '0;
    assign rst_val.enable = (g == 0);

    assign load = we && (sel == SEL_W'(g)) && (field != FLD_RSVD);

    always_comb begin
      nxt = cur_q;
      case (field)
        FLD_LOWER: nxt.lower  = wdata;
        FLD_UPPER: nxt.upper  = wdata;
        FLD_CTRL:  nxt.enable = wdata[0];
        default:   nxt        = cur_q;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cur_q <= rst_val;
      end else if (load) begin
        cur_q <= nxt;
      end
    end

    assign win[g] = cur_q;

    AST_LOWER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel == SEL_W'(g) && field == FLD_LOWER) |=> (win[g].lower == $past(wdata))); // R8
    AST_UPPER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel == SEL_W'(g) && field == FLD_UPPER) |=> (win[g].upper == $past(wdata))); // R8
    AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel == SEL_W'(g) && field == FLD_RSVD) |=> $stable(win[g])); // R8
  end

endmodule

// File: rtl/cs_window_match.sv
module cs_window_match
  import cs_dec_pkg::*;
#(
  parameter int unsigned NUM_CS = CS_NUM
) (
  input  logic [PAGE_W-1:0]        page,
  input  cs_window_t [NUM_CS-1:0]  win,
  output logic [NUM_CS-1:0]        hit
);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cmp
    logic above_lo;
    logic below_hi;
    always_comb begin
      above_lo = (page >= win[g].lower);
      below_hi = (page <= win[g].upper);
      hit[g]   = win[g].enable && above_lo && below_hi;
    end
  end

endmodule

// File: rtl/cs_priority_select.sv
module cs_priority_select #(
  parameter int unsigned NUM_CS = 4
) (
  input  logic              allow,
  input  logic [NUM_CS-1:0] hit,
  output logic [NUM_CS-1:0] grant
);

  logic taken;

  always_comb begin
    grant = '0;
    taken = 1'b0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (allow && hit[i] && !taken) begin
        grant[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end

endmodule

// File: rtl/cs_window_decoder.sv
module cs_window_decoder
  import cs_dec_pkg::*;
#(
  parameter int unsigned NUM_CS = CS_NUM,
  parameter int unsigned ADDR_W = 24,
  localparam int unsigned SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int unsigned IDX_W = SEL_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              mreq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              int_hit,
  input  logic              reg_we,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [PAGE_W-1:0] reg_wdata,
  output logic [NUM_CS-1:0] cs_n
);

  logic rst_meta_q;
  logic rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  cs_window_t [NUM_CS-1:0] win;
  logic [NUM_CS-1:0]       hit;
  logic [NUM_CS-1:0]       grant;
  logic [PAGE_W-1:0]       page;
  logic                    access;
  logic                    allow;
  reg_field_e              field;

  assign field  = reg_field_e'(reg_idx[IDX_W-1 -: 2]);
  assign page   = addr[ADDR_W-1 -: PAGE_W];
  assign access = !mreq_n && (!rd_n || !wr_n);
  assign allow  = access && !int_hit;

  cs_bound_regs #(.NUM_CS(NUM_CS)) u_regs (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .we    (reg_we),
    .sel   (reg_idx[SEL_W-1:0]),
    .field (field),
    .wdata (reg_wdata),
    .win   (win)
  );

  cs_window_match #(.NUM_CS(NUM_CS)) u_match (
    .page (page),
    .win  (win),
    .hit  (hit)
  );

  cs_priority_select #(.NUM_CS(NUM_CS)) u_prio (
    .allow (allow),
    .hit   (hit),
    .grant (grant)
  );

  assign cs_n = ~grant;

  AST_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $onehot0(~cs_n)); // R4
  AST_INTERNAL_WINS: assert property (@(posedge clk) disable iff (!rst_sync_q)
    int_hit |-> (&cs_n)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (mreq_n || (rd_n && wr_n)) |-> (&cs_n)); // R6

  for (genvar g = 0; g < NUM_CS; g++) begin : g_chk
    AST_SEL_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_sync_q)
      !cs_n[g] |-> (win[g].lower <= page && page <= win[g].upper)); // R1
    AST_EMPTY_NEVER: assert property (@(posedge clk) disable iff (!rst_sync_q)
      (win[g].lower > win[g].upper) |-> cs_n[g]); // R3
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_q)
      !win[g].enable |-> cs_n[g]); // R9
    AST_LOWER_FIRST: assert property (@(posedge clk) disable iff (!rst_sync_q)
      !cs_n[g] |-> ((hit & NUM_CS'((1 << g) - 1)) == '0)); // R4
  end

endmodule

// File: tb/sim_cs_window_decoder.sv
`timescale 1ns/1ps
module sim_cs_window_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [23:0] addr;
  logic        mreq_n, rd_n, wr_n, int_hit;
  logic        reg_we;
  logic [3:0]  reg_idx;
  logic [7:0]  reg_wdata;
  logic [3:0]  cs_n;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [7:0] m_lo [4];
  logic [7:0] m_hi [4];
  logic       m_en [4];

  always #2.5 clk = ~clk;

  cs_window_decoder u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .mreq_n(mreq_n), .rd_n(rd_n),
    .wr_n(wr_n), .int_hit(int_hit), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .cs_n(cs_n)
  );

  function automatic logic [3:0] expect_cs(input logic [23:0] a, input logic mq,
                                           input logic r, input logic w, input logic ih);
    logic [3:0] res = 4'hF;
    if (mq || (r && w) || ih) return res;
    for (int i = 0; i < 4; i++) begin
      if (m_en[i] && m_lo[i] <= a[23:16] && a[23:16] <= m_hi[i]) begin
        res[i] = 1'b0;
        return res;
      end
    end
    return res;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      m_lo[i] = 8'h00;
      m_hi[i] = (i == 0) ? 8'hFF : 8'h00;
      m_en[i] = (i == 0);
    end
  endtask

  task automatic write_reg(input int cs, input int fld, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1;
    reg_idx = {fld[1:0], cs[1:0]};
    reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    case (fld)
      0: m_lo[cs] = d;
      1: m_hi[cs] = d;
      2: m_en[cs] = d[0];
      default: ;
    endcase
  endtask

  task automatic probe(input logic [23:0] a, input logic mq, input logic r,
                       input logic w, input logic ih, input string tag);
    logic [3:0] exp_v;
    @(negedge clk);
    addr = a; mreq_n = mq; rd_n = r; wr_n = w; int_hit = ih;
    #1;
    exp_v = expect_cs(a, mq, r, w, ih);
    checks++;
    if (cs_n !== exp_v) begin
      failures++;
      $display("FAIL %s addr=%h cs_n actual=%b expected=%b", tag, a, cs_n, exp_v);
    end
  endtask

  function automatic logic [7:0] pick_page();
    logic [7:0] pool [6] = '{8'h00, 8'h20, 8'h40, 8'h41, 8'h80, 8'hFF};
    if ($urandom_range(0, 3) == 0) return 8'($urandom);
    return pool[$urandom_range(0, 5)] + 8'($urandom_range(0, 2)) - 8'd1;
  endfunction

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; addr = '0; mreq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    int_hit = 1'b0; reg_we = 1'b0; reg_idx = '0; reg_wdata = '0;
    model_reset();
    repeat (3) @(negedge clk);
    probe(24'h123456, 1'b0, 1'b0, 1'b1, 1'b0, "R7 during reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    probe(24'hFFFFFF, 1'b0, 1'b0, 1'b1, 1'b0, "R7 cs0 covers top");
    probe(24'h000000, 1'b0, 1'b1, 1'b0, 1'b0, "R7 cs0 covers bottom");
    probe(24'h000000, 1'b1, 1'b0, 1'b1, 1'b0, "R6 reset idle");

    write_reg(0, 2, 8'h00);
    probe(24'h500000, 1'b0, 1'b0, 1'b1, 1'b0, "R9 cs0 disabled");
    write_reg(2, 0, 8'h40);
    write_reg(2, 1, 8'h40);
    write_reg(2, 2, 8'h01);
    probe(24'h40ABCD, 1'b0, 1'b0, 1'b1, 1'b0, "R2 single page hit");
    probe(24'h410000, 1'b0, 1'b0, 1'b1, 1'b0, "R2 page above");
    probe(24'h3FFFFF, 1'b0, 1'b0, 1'b1, 1'b0, "R2 page below");
    write_reg(3, 0, 8'h90);
    write_reg(3, 1, 8'h80);
    write_reg(3, 2, 8'h01);
    probe(24'h858000, 1'b0, 1'b0, 1'b1, 1'b0, "R3 inverted bounds");
    probe(24'h900000, 1'b0, 1'b1, 1'b0, 1'b0, "R3 inverted at lower");
    write_reg(1, 1, 8'h7F);
    write_reg(1, 2, 8'h01);
    probe(24'h401234, 1'b0, 1'b0, 1'b1, 1'b0, "R4 cs1 beats cs2");
    probe(24'h401234, 1'b0, 1'b0, 1'b1, 1'b1, "R5 internal hit");
    probe(24'h401234, 1'b1, 1'b0, 1'b0, 1'b0, "R6 no request");
    probe(24'h401234, 1'b0, 1'b1, 1'b1, 1'b0, "R6 no strobe");
    probe(24'h401234, 1'b0, 1'b1, 1'b0, 1'b0, "R1 write access");
    write_reg(1, 3, 8'h00);
    probe(24'h401234, 1'b0, 1'b0, 1'b1, 1'b0, "R8 reserved field ignored");
    write_reg(1, 2, 8'hFE);
    probe(24'h401234, 1'b0, 1'b0, 1'b1, 1'b0, "R8 R9 enable bit0 only");
    write_reg(0, 2, 8'h01);
    probe(24'h401234, 1'b0, 1'b0, 1'b1, 1'b0, "R4 cs0 highest priority");

    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 9) < 3) begin
        write_reg($urandom_range(0, 3), $urandom_range(0, 3), pick_page());
      end else begin
        logic mq, r, w, ih;
        string tag;
        mq = ($urandom_range(0, 7) == 0);
        r  = $urandom_range(0, 1);
        w  = (r == 1'b0) ? ($urandom_range(0, 3) == 0) : ($urandom_range(0, 5) == 0);
        ih = ($urandom_range(0, 7) == 0);
        if (mq || (r && w)) tag = "R6 random";
        else if (ih) tag = "R5 random";
        else tag = "R1 R4 random";
        probe({pick_page(), 16'($urandom)}, mq, r, w, ih, tag);
      end
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule